// File: doc/BRIEF.md
# Zero-Latency SECDED Memory Guard

This block sits on the data path of a memory that cannot absorb any extra latency, such as a register file or the data arrays of a cache. On the write side it turns a data word into an extended Hamming codeword that is stored in place of the bare word. On the read side it takes the stored codeword and, within the same clock cycle, returns corrected data together with flags for corrected and uncorrectable errors. No corrected word is written back and nothing scrubs the array in the background.

When the guarded memory is a cache, the host enables flush mode. In this mode any detected error raises a registered flush request, and the cache answers by invalidating and refilling from main memory. That refill takes the place of scrubbing. The request is held for as long as the cache reports that it is busy. Two saturating counters record how many corrected and how many uncorrectable reads were seen. The data width is a parameter and the number of check bits follows from it.

Top module: `secded_guard`

## Requirements
- R1: `wr_code_o` is the codeword of `wr_data_i` in the same cycle. Bit index equals Hamming position. Positions 1, 2, 4, 8, ... hold check bits, and check bit 2^k is the even parity of every other position in 1..CODE_W-1 that has bit k set in its index. Data bit 0 upward fills the remaining positions from 3 upward in ascending order. Bit 0 makes the parity of the whole codeword even. With DATA_W=32 there are 6 check bits and CODE_W is 39.
- R2: A valid read of an intact codeword returns its data on `rd_data_o` in the same cycle, with both error flags low.
- R3: A valid read with one flipped data-position bit returns the original data in the same cycle, with `err_corr_o` high and `err_uncorr_o` low.
- R4: A valid read with one flipped check bit, or with the overall parity bit flipped, returns the original data unchanged and raises `err_corr_o` only.
- R5: A valid read with two flipped bits raises `err_uncorr_o` and not `err_corr_o`. The same applies to an odd number of flips whose syndrome points past position CODE_W-1. In both cases `rd_data_o` carries the raw data positions uncorrected.
- R6: While `rd_valid_i` is low, both flags stay low, and the counters and the flush request ignore the read port.
- R7: With `flush_en_i` high, a valid read with either flag raised makes `flush_req_o` high in the next cycle. When `cache_busy_i` is low and no new error arrives, the request lasts one cycle.
- R8: While `flush_req_o` is high and `cache_busy_i` is high, `flush_req_o` stays high in the next cycle.
- R9: With `flush_en_i` low, errors raise no flush request. They are still counted.
- R10: Each valid corrected read raises `corr_cnt_o` by one in the next cycle. Each valid uncorrectable read does the same to `uncorr_cnt_o`.
- R11: Each counter stops at 2^CNT_W-1 and holds that value.
- R12: A synchronous high `rst_i` clears both counters and the flush request at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_data_i | input | DATA_W | Word to be stored |
| wr_code_o | output | CODE_W | Codeword to write into the memory |
| rd_valid_i | input | 1 | A read codeword is present this cycle |
| rd_code_i | input | CODE_W | Codeword read from the memory |
| rd_data_o | output | DATA_W | Corrected read data |
| err_corr_o | output | 1 | Single error corrected on this read |
| err_uncorr_o | output | 1 | Uncorrectable error on this read |
| flush_en_i | input | 1 | Cache mode: errors request a flush |
| cache_busy_i | input | 1 | Cache is busy; a pending request is held |
| flush_req_o | output | 1 | Flush request to the cache controller |
| corr_cnt_o | output | CNT_W | Saturating count of corrected reads |
| uncorr_cnt_o | output | CNT_W | Saturating count of uncorrectable reads |

## Verification
The codeword, the corrected data and both flags are combinational. They are due in the cycle the stimulus is applied, so the bench compares them one time step after driving the inputs on the falling edge. The flush request and the counters pass through one register and are due one rising edge later. The bench's reference model updates its own copies right after that edge and compares them on the next falling edge. Expected decode results come from the number and position of the bits the bench flipped in a codeword it built itself, never from a syndrome.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    RD_CLEAN = 2'd0,
    RD_FIXED = 2'd1,
    RD_FATAL = 2'd2
  } rd_kind_e;

  // number of Hamming check bits needed for dw data bits
  function automatic int chk_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // codeword position of data bit j (positions that are not powers of two)
  function automatic int data_pos(input int j);
    int seen;
    int res;
    seen = 0;
    res  = 0;
    for (int p = 3; p < 4096; p++) begin
      if (!is_pow2(p) && res == 0) begin
        if (seen == j) res = p;
        seen++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = secded_pkg::chk_bits(DATA_W),
  parameter int CODE_W = DATA_W + CHK_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);

  function automatic logic [CODE_W-1:0] cover_mask(input int k);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int i = 1; i < CODE_W; i++) m[i] = ((i >> k) & 1) == 1;
    return m;
  endfunction

  logic [CODE_W-1:0] body;
  logic [CHK_W-1:0]  chk;

  assign body[0] = 1'b0;

  for (genvar j = 0; j < DATA_W; j++) begin : g_data
    localparam int POS = secded_pkg::data_pos(j);
    assign body[POS]   = data_i[j];
    assign code_o[POS] = data_i[j];
  end

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [CODE_W-1:0] COVER = cover_mask(k);
    assign body[1 << k]   = 1'b0;
    assign chk[k]         = ^(body & COVER);
    assign code_o[1 << k] = chk[k];
  end

  assign code_o[0] = ^{chk, data_i};

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = secded_pkg::chk_bits(DATA_W),
  parameter int CODE_W = DATA_W + CHK_W + 1
) (
  input  logic [CODE_W-1:0]     code_i,
  output logic [DATA_W-1:0]     data_o,
  output secded_pkg::rd_kind_e  kind_o
);

  localparam int LAST = CODE_W - 1;

  function automatic logic [CODE_W-1:0] cover_mask(input int k);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int i = 1; i < CODE_W; i++) m[i] = ((i >> k) & 1) == 1;
    return m;
  endfunction

  logic [CHK_W-1:0]  syn;
  logic              par_odd;
  logic [CODE_W-1:0] flip;
  logic [CODE_W-1:0] fixed;

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    localparam logic [CODE_W-1:0] COVER = cover_mask(k);
    assign syn[k] = ^(code_i & COVER);
  end

  assign par_odd = ^code_i;

  for (genvar i = 0; i < CODE_W; i++) begin : g_flip
    assign flip[i] = par_odd && (syn == CHK_W'(i));
  end

  assign fixed = code_i ^ flip;

  for (genvar j = 0; j < DATA_W; j++) begin : g_out
    localparam int POS = secded_pkg::data_pos(j);
    assign data_o[j] = fixed[POS];
  end

  always_comb begin
    kind_o = secded_pkg::RD_CLEAN;
    if (par_odd) begin
      if (int'(syn) > LAST) kind_o = secded_pkg::RD_FATAL;
      else                  kind_o = secded_pkg::RD_FIXED;
    end else if (syn != '0) begin
      kind_o = secded_pkg::RD_FATAL;
    end
  end

endmodule

// File: rtl/secded_flush.sv
module secded_flush (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hit_i,
  input  logic busy_i,
  output logic req_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) req_o <= 1'b0;
    else       req_o <= hit_i || (req_o && busy_i);
  end

endmodule

// File: rtl/secded_sat_cnt.sv
module secded_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk_i) begin
    if (rst_i)                     cnt_o <= '0;
    else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/secded_guard.sv
module secded_guard #(
  parameter  int DATA_W = 32,
  parameter  int CNT_W  = 8,
  localparam int CHK_W  = secded_pkg::chk_bits(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CODE_W-1:0] wr_code_o,
  input  logic              rd_valid_i,
  input  logic [CODE_W-1:0] rd_code_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_corr_o,
  output logic              err_uncorr_o,
  input  logic              flush_en_i,
  input  logic              cache_busy_i,
  output logic              flush_req_o,
  output logic [CNT_W-1:0]  corr_cnt_o,
  output logic [CNT_W-1:0]  uncorr_cnt_o
);

  secded_pkg::rd_kind_e kind;

  secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_enc (
    .data_i (wr_data_i),
    .code_o (wr_code_o)
  );

  secded_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_dec (
    .code_i (rd_code_i),
    .data_o (rd_data_o),
    .kind_o (kind)
  );

  assign err_corr_o   = rd_valid_i && (kind == secded_pkg::RD_FIXED);
  assign err_uncorr_o = rd_valid_i && (kind == secded_pkg::RD_FATAL);

  secded_flush u_flush (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .hit_i  (flush_en_i && (err_corr_o || err_uncorr_o)),
    .busy_i (cache_busy_i),
    .req_o  (flush_req_o)
  );

  secded_sat_cnt #(.W(CNT_W)) u_cnt_corr (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .inc_i (err_corr_o),
    .cnt_o (corr_cnt_o)
  );

  secded_sat_cnt #(.W(CNT_W)) u_cnt_uncorr (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .inc_i (err_uncorr_o),
    .cnt_o (uncorr_cnt_o)
  );

endmodule

// File: rtl/secded_guard_chk.sv
module secded_guard_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             rd_valid_i,
  input logic             err_corr_o,
  input logic             err_uncorr_o,
  input logic             flush_en_i,
  input logic             cache_busy_i,
  input logic             flush_req_o,
  input logic [CNT_W-1:0] corr_cnt_o,
  input logic [CNT_W-1:0] uncorr_cnt_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic seen_rst = 1'b0;
  logic armed    = 1'b0;

  always_ff @(posedge clk_i) begin
    seen_rst <= seen_rst | rst_i;
    armed    <= seen_rst & ~rst_i;
  end

  // R5: a read is never both corrected and uncorrectable
  p_flags_excl_r5: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    !(err_corr_o && err_uncorr_o));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    !rd_valid_i |-> (!err_corr_o && !err_uncorr_o));

  p_flush_raise_r7: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (flush_en_i && (err_corr_o || err_uncorr_o)) |=> flush_req_o);

  p_flush_drop_r7: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (flush_req_o && !cache_busy_i && !(flush_en_i && (err_corr_o || err_uncorr_o)))
      |=> !flush_req_o);

  p_flush_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (flush_req_o && cache_busy_i) |=> flush_req_o);

  p_corr_step_r10: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    !$stable(corr_cnt_o) |-> (corr_cnt_o == $past(corr_cnt_o) + 1'b1));

  p_uncorr_step_r10: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    !$stable(uncorr_cnt_o) |-> (uncorr_cnt_o == $past(uncorr_cnt_o) + 1'b1));

  p_corr_sat_r11: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (corr_cnt_o == TOP) |=> (corr_cnt_o == TOP));

  p_uncorr_sat_r11: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (uncorr_cnt_o == TOP) |=> (uncorr_cnt_o == TOP));

endmodule

bind secded_guard secded_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .rd_valid_i   (rd_valid_i),
  .err_corr_o   (err_corr_o),
  .err_uncorr_o (err_uncorr_o),
  .flush_en_i   (flush_en_i),
  .cache_busy_i (cache_busy_i),
  .flush_req_o  (flush_req_o),
  .corr_cnt_o   (corr_cnt_o),
  .uncorr_cnt_o (uncorr_cnt_o)
);

// File: tb/secded_guard_test.sv
module secded_guard_test;

  localparam int DW = 32;
  localparam int CW = 39;
  localparam int NW = 8;
  localparam int K_CLEAN = 0;
  localparam int K_FIXED = 1;
  localparam int K_FATAL = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] wr_code;
  logic          rd_valid;
  logic [CW-1:0] rd_code;
  logic [DW-1:0] rd_data;
  logic          err_corr, err_uncorr;
  logic          flush_en, cache_busy, flush_req;
  logic [NW-1:0] corr_cnt, uncorr_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  bit m_flush = 0;
  int m_ccnt  = 0;
  int m_ucnt  = 0;

  always #10 clk = ~clk;

  secded_guard #(.DATA_W(DW), .CNT_W(NW)) uut (
    .clk_i(clk), .rst_i(rst), .wr_data_i(wr_data), .wr_code_o(wr_code),
    .rd_valid_i(rd_valid), .rd_code_i(rd_code), .rd_data_o(rd_data),
    .err_corr_o(err_corr), .err_uncorr_o(err_uncorr), .flush_en_i(flush_en),
    .cache_busy_i(cache_busy), .flush_req_o(flush_req),
    .corr_cnt_o(corr_cnt), .uncorr_cnt_o(uncorr_cnt)
  );

  function automatic logic [CW-1:0] ref_encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[j];
        j++;
      end
    end
    for (int b = 0; b < 6; b++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < CW; p++)
        if (((p >> b) & 1) == 1 && p != (1 << b)) x ^= c[p];
      c[1 << b] = x;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [DW-1:0] ref_raw(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[j] = c[p];
        j++;
      end
    end
    return d;
  endfunction

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  // one clock: drive on the falling edge, compare, then advance the model
  task automatic step(input logic [CW-1:0] code, input int kind, input logic [DW-1:0] orig,
                      input bit v, input bit en, input bit busy, input bit r, input string tag);
    logic [DW-1:0] wd;
    bit hc, hu;
    wd         = $urandom;
    wr_data    = wd;
    rd_code    = code;
    rd_valid   = v;
    flush_en   = en;
    cache_busy = busy;
    rst        = r;
    #1;
    check("R1 wr_code_o", 64'(wr_code), 64'(ref_encode(wd)));
    if (v) begin
      check({tag, " rd_data_o"}, 64'(rd_data),
            64'((kind == K_FATAL) ? ref_raw(code) : orig));
      check({tag, " err_corr_o"}, 64'(err_corr), 64'(kind == K_FIXED));
      check({tag, " err_uncorr_o"}, 64'(err_uncorr), 64'(kind == K_FATAL));
    end else begin
      check("R6 flags while idle", 64'({err_corr, err_uncorr}), 64'(0));
    end
    check("R7 R8 R9 R12 flush_req_o", 64'(flush_req), 64'(m_flush));
    check("R10 R11 R12 corr_cnt_o", 64'(corr_cnt), 64'(m_ccnt));
    check("R10 R11 R12 uncorr_cnt_o", 64'(uncorr_cnt), 64'(m_ucnt));
    hc = v && (kind == K_FIXED);
    hu = v && (kind == K_FATAL);
    @(posedge clk);
    if (r) begin
      m_flush = 0;
      m_ccnt  = 0;
      m_ucnt  = 0;
    end else begin
      m_flush = (en && (hc || hu)) || (m_flush && busy);
      if (hc && m_ccnt < 255) m_ccnt++;
      if (hu && m_ucnt < 255) m_ucnt++;
    end
    @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [CW-1:0] c;
    rst = 1; rd_valid = 0; rd_code = '0; wr_data = '0; flush_en = 0; cache_busy = 0;
    @(negedge clk);
    // R12: reset clears registered state
    for (int i = 0; i < 3; i++) step('0, K_CLEAN, '0, 0, 0, 0, 1, "R12");
    m_flush = 0;

    // R2: intact codewords
    for (int i = 0; i < 20; i++) begin
      d = $urandom;
      step(ref_encode(d), K_CLEAN, d, 1, 1, 0, 0, "R2");
    end
    step(ref_encode('0), K_CLEAN, '0, 1, 1, 0, 0, "R2");
    step(ref_encode('1), K_CLEAN, '1, 1, 1, 0, 0, "R2");

    // R3 / R4: every single bit position
    for (int p = 0; p < CW; p++) begin
      d = $urandom;
      c = ref_encode(d) ^ (39'd1 << p);
      if (p != 0 && (p & (p - 1)) != 0) step(c, K_FIXED, d, 1, 1, 0, 0, "R3");
      else                              step(c, K_FIXED, d, 1, 1, 0, 0, "R4");
    end

    // R5: double errors
    for (int i = 0; i < 25; i++) begin
      int a, b;
      a = $urandom % CW;
      b = (a + 1 + ($urandom % (CW - 1))) % CW;
      d = $urandom;
      c = ref_encode(d) ^ (39'd1 << a) ^ (39'd1 << b);
      step(c, K_FATAL, d, 1, 1, 0, 0, "R5");
    end
    // R5: triple flip at 32,16,8 gives syndrome 56, past the last position
    d = 32'hA5A5_0F0F;
    c = ref_encode(d) ^ (39'd1 << 32) ^ (39'd1 << 16) ^ (39'd1 << 8);
    step(c, K_FATAL, d, 1, 1, 0, 0, "R5");

    // R6: corrupted words while not valid
    for (int i = 0; i < 4; i++) begin
      d = $urandom;
      step(ref_encode(d) ^ 39'd6, K_FATAL, d, 0, 1, 0, 0, "R6");
    end

    // R9: errors with flush mode off
    d = $urandom;
    step(ref_encode(d) ^ 39'd8, K_FIXED, d, 1, 0, 0, 0, "R9");
    step(ref_encode(d) ^ 39'd24, K_FATAL, d, 1, 0, 0, 0, "R9");
    step(ref_encode(d), K_CLEAN, d, 1, 0, 0, 0, "R9");

    // R7 / R8: request held while busy, then released
    d = $urandom;
    step(ref_encode(d) ^ 39'd32, K_FIXED, d, 1, 1, 1, 0, "R8");
    for (int i = 0; i < 4; i++) step(ref_encode(d), K_CLEAN, d, 1, 1, 1, 0, "R8");
    step(ref_encode(d), K_CLEAN, d, 1, 1, 0, 0, "R7");
    step(ref_encode(d), K_CLEAN, d, 1, 1, 0, 0, "R7");
    step(ref_encode(d), K_CLEAN, d, 1, 1, 0, 0, "R7");

    // R10 / R11: drive both counters to saturation and beyond
    for (int i = 0; i < 260; i++) begin
      d = $urandom;
      step(ref_encode(d) ^ (39'd1 << (i % CW)), K_FIXED, d, 1, 1, 0, 0, "R11");
    end
    for (int i = 0; i < 250; i++) begin
      d = $urandom;
      step(ref_encode(d) ^ 39'd3, K_FATAL, d, 1, 1, 0, 0, "R11");
    end
    step(ref_encode(d), K_CLEAN, d, 1, 1, 0, 0, "R11");
    check("R11 corr_cnt_o saturated", 64'(corr_cnt), 64'(255));

    // R12: reset again from a busy state
    step('0, K_CLEAN, '0, 0, 0, 0, 1, "R12");
    step('0, K_CLEAN, '0, 0, 0, 0, 0, "R12");
    check("R12 corr_cnt_o after reset", 64'(corr_cnt), 64'(0));

    summary();
    $finish;
  end

endmodule